// File: doc/BRIEF.md
# Dual-Channel Converter Input Front End

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. It takes parallel sample words from external buses and hands them to two holding registers, one per channel (I and Q), whose contents drive the analog core. Each holding-register update comes with a one-cycle load pulse.

Two operating modes exist. In dual-bus mode each channel has its own data bus, write strobe and update clock. A write strobe edge captures the bus into the channel's input latch. A later update clock edge moves that latch into the holding register. In interleaved mode a single bus, a single write strobe and a single update clock serve both channels. A steering line chooses which input latch receives each word, and the latch that is not chosen keeps its value. The update clock is divided by two, and every second edge loads both holding registers in the same cycle. An alignment input holds the divider in a known phase, so that the right pair of words is loaded together. A sleep input stops all holding-register updates.

All inputs are sampled by one fast system clock. The strobe, update-clock and alignment inputs pass through a synchronizer and an edge detector. The data buses and the steering line must be stable around each strobe edge for the length of the synchronizer.

Top module: `dual_dac_front`

## Requirements
- R1: When `rst_n` is sampled low, both input latches and both holding registers clear to 0 and both load pulses are low.
- R2: With `bus_mode_i` = 1 (dual-bus mode), a rising edge of `wr_a_i` captures `data_a_i` into the I input latch. A later rising edge of `upd_a_i` copies that latch into `word_i_o` and raises `load_i_o` for exactly one cycle. The effect appears on the third system clock edge after the input rises. Without an update edge, `word_i_o` does not change.
- R3: In dual-bus mode, when a channel's update edge and write edge are seen in the same system cycle, the holding register takes the latch content from before that write. The new word reaches the register on the next update edge.
- R4: In dual-bus mode, an update edge that follows that channel's write edge by 1 to MIN_GAP-1 system cycles (default MIN_GAP = 2, so 1 cycle) is a timing violation. The holding register keeps its value and no load pulse is produced. The latched word is kept for the next valid update edge.
- R5: In dual-bus mode the Q channel behaves exactly as in R2, using `data_b_i`, `wr_b_i` and `upd_b_i`. Activity on one channel never changes the other channel's register or load pulse.
- R6: With `bus_mode_i` = 0 (interleaved mode), a `wr_a_i` rising edge writes `data_a_i` into the I latch when `sel_i` = 1 and into the Q latch when `sel_i` = 0. The other latch keeps its value. `data_b_i`, `wr_b_i` and `upd_b_i` have no effect.
- R7: In interleaved mode, `upd_a_i` is divided by two. Every second rising edge loads both holding registers, and `load_i_o` and `load_q_o` pulse together in that same cycle.
- R8: In interleaved mode, while `align_i` is high, no load happens and the divider is held at phase 0. The first `upd_a_i` rising edge after `align_i` falls loads both registers.
- R9: While `sleep_i` is high, both holding registers keep their values and both load pulses stay low. Input latches still capture writes. `sleep_i` must be tied low for normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode_i | input | 1 | 1 = dual-bus mode, 0 = interleaved mode |
| data_a_i | input | WORD_W | I-channel bus; the only bus used in interleaved mode; bit 11 is the MSB |
| data_b_i | input | WORD_W | Q-channel bus (dual-bus mode only) |
| wr_a_i | input | 1 | I write strobe; the shared strobe in interleaved mode |
| wr_b_i | input | 1 | Q write strobe (dual-bus mode only) |
| upd_a_i | input | 1 | I update clock; the shared clock in interleaved mode |
| upd_b_i | input | 1 | Q update clock (dual-bus mode only) |
| sel_i | input | 1 | Interleaved steering: 1 = I latch, 0 = Q latch |
| align_i | input | 1 | Interleaved divider alignment; high holds the divider |
| sleep_i | input | 1 | Power-down; high freezes the holding registers |
| word_i_o | output | WORD_W | I holding register |
| word_q_o | output | WORD_W | Q holding register |
| load_i_o | output | 1 | One-cycle pulse when `word_i_o` is loaded |
| load_q_o | output | 1 | One-cycle pulse when `word_q_o` is loaded |

## Verification
A write into an input latch and a transfer out of that same latch can fall in the same system cycle. The bench provokes this in dual-bus mode by raising the write strobe and the update clock on the same system clock edge. It then expects the holding register to show the old latch word, and the new word only after a second update edge. In interleaved mode, the divided load and a write to the unselected latch are staged around each other. The bench checks that the word loaded into each register is the one latched before the loading edge.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding and the bit layout of the synchronized control vector.
// Assumes: every module of the front end imports it.
package dacif_pkg;
    typedef enum logic {
        BUS_IQ   = 1'b0,
        BUS_DUAL = 1'b1
    } bus_mode_e;

    localparam int unsigned SIG_WR_A  = 0;
    localparam int unsigned SIG_WR_B  = 1;
    localparam int unsigned SIG_UPD_A = 2;
    localparam int unsigned SIG_UPD_B = 3;
    localparam int unsigned SIG_ALIGN = 4;
    localparam int unsigned SIG_COUNT = 5;
endpackage

// File: rtl/dacif_edge_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchronizer with rising-edge detection on each bit.
// Assumes: STAGES >= 1; each input level is held for at least two system cycles.
module dacif_edge_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: sample the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            // Later stages: shift the sampled value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign level_o = stage_q[STAGES-1];

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;
endmodule

// File: rtl/dacif_gap_check.sv
`timescale 1ns/1ps
// Module: flags an update edge that trails a write edge by fewer than MIN_GAP cycles.
// Assumes: both edge inputs are single-cycle pulses in the system clock domain.
module dacif_gap_check #(
    parameter int unsigned MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_rise_i,
    input  logic upd_rise_i,
    output logic viol_o
);
    localparam int unsigned GW = $clog2(MIN_GAP) + 1;
    localparam logic [GW-1:0] SAT = GW'(MIN_GAP - 1);

    logic [GW-1:0] gap_q;

    // Count cycles since the last write edge, saturating at SAT.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= SAT;
        else if (wr_rise_i)        gap_q <= '0;
        else if (gap_q < SAT)      gap_q <= gap_q + 1'b1;
    end

    assign viol_o = upd_rise_i && !wr_rise_i && (gap_q < SAT);
endmodule

// File: rtl/dacif_iq_divider.sv
`timescale 1ns/1ps
// Module: divide-by-two update generator for interleaved mode, with a phase hold.
// Assumes: clk_rise_i is a single-cycle edge pulse; phase 0 means the next edge loads.
module dacif_iq_divider (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic align_i,
    input  logic clk_rise_i,
    output logic load_o
);
    logic phase_q;

    // Toggle the phase on every shared clock edge; hold it at 0 while aligning or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    phase_q <= 1'b0;
        else if (!enable_i || align_i) phase_q <= 1'b0;
        else if (clk_rise_i)           phase_q <= ~phase_q;
    end

    assign load_o = enable_i && !align_i && clk_rise_i && !phase_q;
endmodule

// File: rtl/dual_dac_front.sv
`timescale 1ns/1ps
// Module: dual-channel converter input front end (dual-bus or interleaved).
// Assumes: data_a_i, data_b_i and sel_i are stable while a strobe edge passes the synchronizer;
//          the whole block runs on clk with a synchronous active-low reset.
module dual_dac_front #(
    parameter int unsigned WORD_W      = 12,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_GAP     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode_i,
    input  logic [WORD_W-1:0] data_a_i,
    input  logic [WORD_W-1:0] data_b_i,
    input  logic              wr_a_i,
    input  logic              wr_b_i,
    input  logic              upd_a_i,
    input  logic              upd_b_i,
    input  logic              sel_i,
    input  logic              align_i,
    input  logic              sleep_i,
    output logic [WORD_W-1:0] word_i_o,
    output logic [WORD_W-1:0] word_q_o,
    output logic              load_i_o,
    output logic              load_q_o
);
    import dacif_pkg::*;

    localparam int unsigned NCH = 2;

    logic [SIG_COUNT-1:0] raw_s;
    logic [SIG_COUNT-1:0] lvl_s;
    logic [SIG_COUNT-1:0] rise_s;
    logic [NCH-1:0]       wr_ev;
    logic [NCH-1:0]       upd_ev;
    logic [NCH-1:0]       viol;
    logic                 dual_mode;
    logic                 div_load;
    logic [WORD_W-1:0]    lat_i_q, lat_q_q, lat_i_d, lat_q_d;
    logic                 ld_i_d, ld_q_d;
    logic                 live_q;

    // Gather the asynchronous control inputs into one vector.
    always_comb begin
        raw_s            = '0;
        raw_s[SIG_WR_A]  = wr_a_i;
        raw_s[SIG_WR_B]  = wr_b_i;
        raw_s[SIG_UPD_A] = upd_a_i;
        raw_s[SIG_UPD_B] = upd_b_i;
        raw_s[SIG_ALIGN] = align_i;
    end

    dacif_edge_sync #(
        .WIDTH  (SIG_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_s),
        .level_o (lvl_s),
        .rise_o  (rise_s)
    );

    assign dual_mode = (bus_mode_e'(bus_mode_i) == BUS_DUAL);
    assign wr_ev     = {rise_s[SIG_WR_B],  rise_s[SIG_WR_A]};
    assign upd_ev    = {rise_s[SIG_UPD_B], rise_s[SIG_UPD_A]};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_gap
        dacif_gap_check #(
            .MIN_GAP (MIN_GAP)
        ) u_gap (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_rise_i  (wr_ev[ch]),
            .upd_rise_i (upd_ev[ch]),
            .viol_o     (viol[ch])
        );
    end

    dacif_iq_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (!dual_mode),
        .align_i    (lvl_s[SIG_ALIGN]),
        .clk_rise_i (upd_ev[0]),
        .load_o     (div_load)
    );

    // Input latch next state: steer the captured word, feed back the unselected latch.
    always_comb begin
        lat_i_d = lat_i_q;
        lat_q_d = lat_q_q;
        if (dual_mode) begin
            if (wr_ev[0]) lat_i_d = data_a_i;
            if (wr_ev[1]) lat_q_d = data_b_i;
        end else if (wr_ev[0]) begin
            if (sel_i) lat_i_d = data_a_i;
            else       lat_q_d = data_a_i;
        end
    end

    // Holding-register load decision per channel, blocked by violation or sleep.
    always_comb begin
        if (dual_mode) begin
            ld_i_d = upd_ev[0] && !viol[0];
            ld_q_d = upd_ev[1] && !viol[1];
        end else begin
            ld_i_d = div_load;
            ld_q_d = div_load;
        end
        ld_i_d = ld_i_d && !sleep_i;
        ld_q_d = ld_q_d && !sleep_i;
    end

    // Input latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_i_q <= '0;
            lat_q_q <= '0;
        end else begin
            lat_i_q <= lat_i_d;
            lat_q_q <= lat_q_d;
        end
    end

    // Holding registers and their load pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_i_o <= '0;
            word_q_o <= '0;
            load_i_o <= 1'b0;
            load_q_o <= 1'b0;
        end else begin
            load_i_o <= ld_i_d;
            load_q_o <= ld_q_d;
            if (ld_i_d) word_i_o <= lat_i_q;
            if (ld_q_d) word_q_o <= lat_q_q;
        end
    end

    // Marks that the previous edge was a normal, non-reset edge (for assertions).
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !load_i_o) |-> $stable(word_i_o))
        else $error("I register changed without a load pulse");

    assert_gap_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(dual_mode && viol[0])) |-> !load_i_o)
        else $error("I register loaded on a timing violation");

    assert_pair_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(dual_mode)) |-> (load_i_o == load_q_o))
        else $error("interleaved loads not paired");

    assert_align_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(dual_mode) && $past(lvl_s[SIG_ALIGN])) |-> !load_i_o)
        else $error("load while alignment held");

    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sleep_i)) |-> (!load_i_o && !load_q_o))
        else $error("load pulse during sleep");
endmodule

// File: tb/dual_dac_front_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each; inputs driven and outputs sampled at negedge.
module dual_dac_front_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_mode_i;
    logic [11:0] data_a_i, data_b_i;
    logic        wr_a_i, wr_b_i, upd_a_i, upd_b_i;
    logic        sel_i, align_i, sleep_i;
    logic [11:0] word_i_o, word_q_o;
    logic        load_i_o, load_q_o;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_i = 0;
    int cnt_q = 0;

    dual_dac_front u_dual_dac_front (
        .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode_i),
        .data_a_i(data_a_i), .data_b_i(data_b_i),
        .wr_a_i(wr_a_i), .wr_b_i(wr_b_i), .upd_a_i(upd_a_i), .upd_b_i(upd_b_i),
        .sel_i(sel_i), .align_i(align_i), .sleep_i(sleep_i),
        .word_i_o(word_i_o), .word_q_o(word_q_o),
        .load_i_o(load_i_o), .load_q_o(load_q_o)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
        cnt_i += int'(load_i_o);
        cnt_q += int'(load_q_o);
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic clr();
        cnt_i = 0;
        cnt_q = 0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bus_mode_i = 1'b1; data_a_i = '0; data_b_i = '0;
        wr_a_i = 0; wr_b_i = 0; upd_a_i = 0; upd_b_i = 0;
        sel_i = 0; align_i = 0; sleep_i = 0;
        idle(4);
        chk("R1", "word_i in reset", int'(word_i_o), 0);
        chk("R1", "word_q in reset", int'(word_q_o), 0);
        rst_n = 1'b1;
        clr();
        idle(4);
        chk("R1", "no loads after reset", cnt_i + cnt_q, 0);
    endtask

    task automatic t_dual_basic();
        data_a_i = 12'h123; wr_a_i = 1;
        idle(2);
        upd_a_i = 1; clr();
        idle(2);
        chk("R2", "no load before latency", int'(load_i_o), 0);
        tick();
        chk("R2", "load pulse on third edge", int'(load_i_o), 1);
        chk("R2", "word_i loaded", int'(word_i_o), 'h123);
        tick();
        chk("R2", "pulse one cycle", int'(load_i_o), 0);
        wr_a_i = 0; upd_a_i = 0;
        idle(4);
        chk("R2", "single load", cnt_i, 1);
    endtask

    task automatic t_same_cycle();
        data_a_i = 12'h111; wr_a_i = 1;
        idle(3); wr_a_i = 0; idle(3);
        chk("R2", "write alone keeps register", int'(word_i_o), 'h123);
        data_a_i = 12'h222; wr_a_i = 1; upd_a_i = 1; clr();
        idle(6);
        chk("R3", "same-cycle takes old latch", int'(word_i_o), 'h111);
        chk("R3", "same-cycle load count", cnt_i, 1);
        wr_a_i = 0; upd_a_i = 0; idle(3);
        upd_a_i = 1; idle(6); upd_a_i = 0; idle(2);
        chk("R3", "new word on next update", int'(word_i_o), 'h222);
    endtask

    task automatic t_violation();
        data_a_i = 12'h3F0; wr_a_i = 1;
        tick();
        upd_a_i = 1; clr();
        idle(6);
        chk("R4", "violation blocks load", cnt_i, 0);
        chk("R4", "violation keeps register", int'(word_i_o), 'h222);
        wr_a_i = 0; upd_a_i = 0; idle(3);
        upd_a_i = 1; clr(); idle(6); upd_a_i = 0; idle(2);
        chk("R4", "latched word kept for next update", int'(word_i_o), 'h3F0);
        chk("R4", "later update loads", cnt_i, 1);
    endtask

    task automatic t_independent();
        data_b_i = 12'hABC; wr_b_i = 1;
        idle(2);
        upd_b_i = 1; clr();
        idle(6);
        chk("R5", "word_q loaded", int'(word_q_o), 'hABC);
        chk("R5", "q load count", cnt_q, 1);
        chk("R5", "i channel untouched", cnt_i, 0);
        chk("R5", "word_i untouched", int'(word_i_o), 'h3F0);
        wr_b_i = 0; upd_b_i = 0; idle(3);
    endtask

    task automatic t_interleave();
        align_i = 1; bus_mode_i = 0; idle(4);
        align_i = 0; idle(4);
        sel_i = 1; data_a_i = 12'h5A5; wr_a_i = 1; idle(3); wr_a_i = 0; idle(3);
        sel_i = 0; data_a_i = 12'h3C3; wr_a_i = 1; idle(3); wr_a_i = 0; idle(3);
        clr(); upd_a_i = 1; idle(5); upd_a_i = 0; idle(2);
        chk("R7", "first edge loads I", cnt_i, 1);
        chk("R7", "first edge loads Q", cnt_q, 1);
        chk("R6", "I got sel=1 word", int'(word_i_o), 'h5A5);
        chk("R6", "Q got sel=0 word", int'(word_q_o), 'h3C3);
        clr(); upd_a_i = 1; idle(5); upd_a_i = 0; idle(2);
        chk("R7", "second edge no load", cnt_i + cnt_q, 0);
        sel_i = 1; data_a_i = 12'h777; wr_a_i = 1; idle(3); wr_a_i = 0; idle(3);
        data_b_i = 12'h0F0; wr_b_i = 1; upd_b_i = 1; clr(); idle(4);
        wr_b_i = 0; upd_b_i = 0; idle(3);
        chk("R6", "Q-side inputs ignored", cnt_i + cnt_q, 0);
        clr(); upd_a_i = 1; idle(5); upd_a_i = 0; idle(2);
        chk("R7", "third edge loads pair", cnt_i + cnt_q, 2);
        chk("R6", "I updated", int'(word_i_o), 'h777);
        chk("R6", "unselected Q held", int'(word_q_o), 'h3C3);
    endtask

    task automatic t_align();
        sel_i = 1; data_a_i = 12'h101; wr_a_i = 1; idle(3); wr_a_i = 0; idle(3);
        sel_i = 0; data_a_i = 12'h202; wr_a_i = 1; idle(3); wr_a_i = 0; idle(3);
        align_i = 1; idle(3); clr();
        for (int k = 0; k < 2; k++) begin
            upd_a_i = 1; idle(3); upd_a_i = 0; idle(3);
        end
        chk("R8", "no load while aligning", cnt_i + cnt_q, 0);
        align_i = 0; idle(3);
        clr(); upd_a_i = 1; idle(5); upd_a_i = 0; idle(2);
        chk("R8", "first edge after release loads", cnt_i + cnt_q, 2);
        chk("R8", "I pair word", int'(word_i_o), 'h101);
        chk("R8", "Q pair word", int'(word_q_o), 'h202);
    endtask

    task automatic t_sleep();
        bus_mode_i = 1; idle(3);
        sleep_i = 1; data_a_i = 12'h456; wr_a_i = 1; idle(2);
        upd_a_i = 1; clr(); idle(6);
        chk("R9", "no load in sleep", cnt_i + cnt_q, 0);
        chk("R9", "register held in sleep", int'(word_i_o), 'h101);
        wr_a_i = 0; upd_a_i = 0; idle(2);
        sleep_i = 0; idle(2);
        upd_a_i = 1; clr(); idle(6); upd_a_i = 0; idle(2);
        chk("R9", "latch captured during sleep", int'(word_i_o), 'h456);
        chk("R9", "load resumes", cnt_i, 1);
    endtask

    initial begin
        t_reset();
        t_dual_basic();
        t_same_cycle();
        t_violation();
        t_independent();
        t_interleave();
        t_align();
        t_sleep();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule